// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

This block drives a line-rate horizontal sync pulse from a pixel-position counter clocked by the output sample clock. Each line the counter steps from zero up to one less than the programmed line length and then returns to zero. When the upstream sync detector reports a valid source, a line-start strobe snaps the counter back to zero, so the pulse follows the incoming video. Without a valid source the counter free-runs at the programmed length, so the pulse continues at the nominal line rate.

The leading and trailing edges of the pulse are set by two position inputs, in steps of one sample clock. A window whose end position is below its start position wraps across the line boundary. All three programming inputs are copied into an active set only at a line boundary, so changing them mid-line cannot cut a pulse short.

A two-state controller holds the tracking mode. The states are FREE (strobes ignored) and TRACK (strobes honoured). The transition FREE to TRACK is taken on any clock edge that samples the valid input high. The transition TRACK to FREE is taken on any edge that samples it low.

Top module: `hsync_gen`

## Requirements
- R1: During and right after reset, the position output is 0 and the controller is in FREE. The active start, end and length are 0, 64 and 858, so the sync output reads 1.
- R2: Without a honoured strobe, the position rises by one on each clock edge. On the edge after it reaches the active length minus one, it returns to 0.
- R3: An edge that samples the line-start strobe high while in TRACK, with the valid input also high, sets the position to 0 on that edge.
- R4: The strobe is ignored, and the position keeps counting as in R2, on an edge that samples the valid input low. It is also ignored on the first edge at which valid is sampled high, because the controller is still in FREE there.
- R5: Sync is high when the active start is at most the active end and start <= position < end. When end is below start it is high when position >= start or position < end. When start equals end it is never high.
- R6: The start, end and length inputs are copied into the active set only on an edge where the position becomes 0, whether by wrap or by strobe. At any other time, input changes leave sync and the wrap point unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle line-start detect strobe |
| src_valid | input | 1 | High while a video source is detected |
| start_pos | input | 10 | Position of the sync leading edge |
| end_pos | input | 10 | Position of the sync trailing edge |
| line_len | input | 10 | Nominal line length in sample clocks |
| hsync | output | 1 | Horizontal sync pulse |
| pix_pos | output | 10 | Current position within the line |

## Verification
Every effect lands on the clock edge that samples its cause. The position, the active configuration and the mode all change at that edge. Sync is decoded combinationally from registered state, so it changes with them, and no result arrives more than one edge after its stimulus. The bench drives inputs on the falling edge and checks both outputs on the next falling edge, against a position it derives as cycles-since-boundary modulo the line length. It tracks which configuration was active when that boundary occurred, which covers the one-line delay on new programming values.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic {
        HS_FREE  = 1'b0,
        HS_TRACK = 1'b1
    } hs_mode_e;
endpackage

// File: rtl/hs_mode_fsm.sv
module hs_mode_fsm
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_valid,
    input  logic line_start,
    output logic trk,
    output logic reload
);
    hs_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_FREE:  if (src_valid)  state_d = HS_TRACK;
            HS_TRACK: if (!src_valid) state_d = HS_FREE;
            default:  state_d = HS_FREE;
        endcase
    end

    always_comb begin
        trk    = 1'b0;
        reload = 1'b0;
        unique case (state_q)
            HS_FREE:  begin
                trk    = 1'b0;
                reload = 1'b0;
            end
            HS_TRACK: begin
                trk    = 1'b1;
                reload = src_valid && line_start;
            end
            default:  begin
                trk    = 1'b0;
                reload = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hs_pos_ctr.sv
module hs_pos_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic [W-1:0] len_act,
    output logic [W-1:0] pos,
    output logic         boundary
);
    localparam int EW = W + 1;

    logic [EW-1:0] pos_inc;

    assign pos_inc  = EW'(pos) + EW'(1);
    assign boundary = reload || (pos_inc >= EW'(len_act));

    always_ff @(posedge clk) begin
        if (!rst_n)        pos <= '0;
        else if (boundary) pos <= '0;
        else               pos <= pos_inc[W-1:0];
    end
endmodule

// File: rtl/hs_cfg_shadow.sv
module hs_cfg_shadow #(
    parameter int W         = 10,
    parameter int DEF_START = 0,
    parameter int DEF_END   = 64,
    parameter int DEF_LEN   = 858
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] start_in,
    input  logic [W-1:0] end_in,
    input  logic [W-1:0] len_in,
    output logic [W-1:0] start_act,
    output logic [W-1:0] end_act,
    output logic [W-1:0] len_act
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_act <= W'(DEF_START);
            end_act   <= W'(DEF_END);
            len_act   <= W'(DEF_LEN);
        end else if (load) begin
            start_act <= start_in;
            end_act   <= end_in;
            len_act   <= len_in;
        end
    end
endmodule

// File: rtl/hs_window.sv
module hs_window #(
    parameter int W = 10
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         active
);
    logic ge_lo, lt_hi;

    always_comb begin
        ge_lo = (pos >= lo);
        lt_hi = (pos < hi);
        if (lo <= hi) active = ge_lo && lt_hi;
        else          active = ge_lo || lt_hi;
    end
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
    parameter int POS_W     = 10,
    parameter int DEF_START = 0,
    parameter int DEF_END   = 64,
    parameter int DEF_LEN   = 858
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             src_valid,
    input  logic [POS_W-1:0] start_pos,
    input  logic [POS_W-1:0] end_pos,
    input  logic [POS_W-1:0] line_len,
    output logic             hsync,
    output logic [POS_W-1:0] pix_pos
);
    logic             mode_trk;
    logic             reload;
    logic             boundary;
    logic [POS_W-1:0] start_act, end_act, len_act;

    hs_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (src_valid),
        .line_start (line_start),
        .trk        (mode_trk),
        .reload     (reload)
    );

    hs_pos_ctr #(.W(POS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .len_act  (len_act),
        .pos      (pix_pos),
        .boundary (boundary)
    );

    hs_cfg_shadow #(
        .W         (POS_W),
        .DEF_START (DEF_START),
        .DEF_END   (DEF_END),
        .DEF_LEN   (DEF_LEN)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (boundary),
        .start_in  (start_pos),
        .end_in    (end_pos),
        .len_in    (line_len),
        .start_act (start_act),
        .end_act   (end_act),
        .len_act   (len_act)
    );

    hs_window #(.W(POS_W)) u_win (
        .pos    (pix_pos),
        .lo     (start_act),
        .hi     (end_act),
        .active (hsync)
    );
endmodule

// File: rtl/hs_gen_chk.sv
module hs_gen_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         src_valid,
    input logic         line_start,
    input logic         trk,
    input logic [W-1:0] pix_pos,
    input logic [W-1:0] start_act,
    input logic [W-1:0] end_act,
    input logic [W-1:0] len_act,
    input logic         hsync
);
    localparam int EW = W + 1;

    logic honoured;
    logic at_end;
    assign honoured = trk && src_valid && line_start;
    assign at_end   = (EW'(pix_pos) + EW'(1)) >= EW'(len_act);

    p_reload_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        honoured |=> (pix_pos == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!honoured && !at_end) |=> (pix_pos == $past(pix_pos) + W'(1)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!honoured && at_end) |=> (pix_pos == '0));

    p_strobe_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !trk && !at_end) |=> (pix_pos != '0));

    p_mode_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid |=> trk);

    p_mode_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !src_valid |=> !trk);

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_pos != '0) |-> ($stable(start_act) && $stable(end_act) && $stable(len_act)));

    p_empty_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_act == end_act) |-> !hsync);
endmodule

bind hsync_gen hs_gen_chk #(.W(POS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .line_start (line_start),
    .trk        (mode_trk),
    .pix_pos    (pix_pos),
    .start_act  (start_act),
    .end_act    (end_act),
    .len_act    (len_act),
    .hsync      (hsync)
);

// File: tb/sim_hsync_gen.sv
module sim_hsync_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_start;
    logic       src_valid;
    logic [9:0] start_pos, end_pos, line_len;
    logic       hsync;
    logic [9:0] pix_pos;

    int checks = 0;
    int errors = 0;
    int kpos   = 0;
    bit done   = 0;

    hsync_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .src_valid  (src_valid),
        .start_pos  (start_pos),
        .end_pos    (end_pos),
        .line_len   (line_len),
        .hsync      (hsync),
        .pix_pos    (pix_pos)
    );

    always #4 clk = ~clk;

    function automatic bit win(input int p, input int s, input int e);
        if (s <= e) return (p >= s) && (p < e);
        return (p >= s) || (p < e);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance n cycles; expected position is cycles since boundary modulo L.
    task automatic run_cycles(input int n, input int L, input int S, input int E, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            kpos = (kpos + 1) % L;
            chk(pix_pos == 10'(kpos), {req, " pos"}, int'(pix_pos), kpos);
            chk(hsync == win(kpos, S, E), {req, " hsync"}, int'(hsync), int'(win(kpos, S, E)));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sv[5];
        int ev[4];
        sv = '{0, 3, 7, 15, 19};
        ev = '{0, 5, 12, 19};
        rst_n = 1'b0; line_start = 1'b0; src_valid = 1'b0;
        start_pos = 10'd3; end_pos = 10'd8; line_len = 10'd20;
        repeat (3) @(negedge clk);
        // R1: reset state with default window 0..64
        chk(pix_pos == 10'd0, "R1 pos", int'(pix_pos), 0);
        chk(hsync == 1'b1, "R1 hsync", int'(hsync), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_pos == 10'd1, "R2 count", int'(pix_pos), 1);
        // R4: strobe on first valid cycle is ignored (still FREE)
        src_valid = 1'b1; line_start = 1'b1;
        @(negedge clk);
        chk(pix_pos == 10'd2, "R4 first-valid strobe", int'(pix_pos), 2);
        // R3: strobe now honoured; config 3..8 len 20 loads (R6)
        kpos = -1;
        run_cycles(1, 20, 3, 8, "R3 reload");
        line_start = 1'b0;
        run_cycles(45, 20, 3, 8, "R2 wrap");

        // R5 sweep over start/end pairs, each started by a strobe
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 4; b++) begin
                start_pos = 10'(sv[a]); end_pos = 10'(ev[b]);
                line_start = 1'b1;
                kpos = -1;
                run_cycles(1, 20, sv[a], ev[b], "R3 sweep reload");
                line_start = 1'b0;
                run_cycles(40, 20, sv[a], ev[b], "R5 window");
            end
        end

        // R6: mid-line change takes effect only at next boundary
        start_pos = 10'd2; end_pos = 10'd6; line_len = 10'd20;
        line_start = 1'b1;
        kpos = -1;
        run_cycles(1, 20, 2, 6, "R3 reload");
        line_start = 1'b0;
        run_cycles(5, 20, 2, 6, "R6 old line");
        start_pos = 10'd10; end_pos = 10'd4; line_len = 10'd12;
        run_cycles(14, 20, 2, 6, "R6 held config");
        kpos = -1;
        run_cycles(30, 12, 10, 4, "R6 new config");

        // R4: strobes with valid low are ignored; free-run at length 12
        src_valid = 1'b0; line_start = 1'b1;
        run_cycles(1, 12, 10, 4, "R4 valid-drop strobe");
        run_cycles(30, 12, 10, 4, "R4 free-run strobes");
        line_start = 1'b0;
        run_cycles(13, 12, 10, 4, "R2 free-run");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule